// File: doc/BRIEF.md
# Accumulator Logic, Rotate and Compare Unit

This block is the logical half of an 8-bit accumulator datapath. It holds an accumulator register and a five-bit flag register (sign, zero, auxiliary carry, parity, carry). On each clock edge where the execute strobe is high, it applies the selected operation to the accumulator and an operand. The operand has already been fetched by the surrounding logic from a register, from memory or from an immediate byte.

The supported operations are bitwise AND, OR and XOR, an unsigned compare, four rotates (plain and through carry, each way), accumulator complement, carry complement and carry set. Each operation has its own rule for which flags it writes. Compare only updates flags and never writes the accumulator. Rotates touch nothing but carry, and the complement and carry operations leave the remaining flags alone. Arithmetic, addressing and instruction decode belong to neighbouring blocks.

The reset input is asynchronous and active low. Its release passes through a two-stage synchronizer, so the registers leave reset two rising edges after `rst_n` goes high.

Top module: `acc_logic_unit`

## Requirements
- R1: While reset is active, the accumulator and all flags are 0. The flag bus layout is bit 4 sign, bit 3 zero, bit 2 auxiliary carry, bit 1 parity, bit 0 carry. The reset is asynchronous to assert, and the registers leave reset on the second rising edge after `rst_n` goes high.
- R2: When `exec_en` is 0, or when `op_sel` is 11 to 15, the accumulator and flags hold their values.
- R3: AND (`op_sel`=0) writes A&operand to the accumulator. Sign becomes bit 7 of the result, zero is set when the result is 0, carry is cleared and auxiliary carry is set.
- R4: XOR (`op_sel`=1) and OR (`op_sel`=2) write A^operand or A|operand to the accumulator. Sign and zero come from the result, and carry and auxiliary carry are both cleared.
- R5: Compare (`op_sel`=3) leaves the accumulator unchanged. Carry is set when A<operand, zero is set when they are equal, and both are cleared when A>operand. Both values are treated as unsigned.
- R6: Compare sets sign to bit 7 of (A-operand) mod 256 and parity from that difference. Auxiliary carry is set when A[3:0] < operand[3:0].
- R7: Rotate left (`op_sel`=4) moves bit 7 into bit 0 and into carry. Rotate right (`op_sel`=5) moves bit 0 into bit 7 and into carry. Sign, zero, auxiliary carry and parity do not change.
- R8: Rotate left through carry (`op_sel`=6) shifts the old carry into bit 0 and bit 7 into carry. Rotate right through carry (`op_sel`=7) shifts the old carry into bit 7 and bit 0 into carry. Other flags do not change.
- R9: Complement accumulator (`op_sel`=8) inverts all accumulator bits and leaves every flag unchanged.
- R10: Complement carry (`op_sel`=9) inverts carry. Set carry (`op_sel`=10) forces carry to 1. The accumulator and the other four flags do not change.
- R11: Wherever parity is written, it is 1 when the 8-bit value has an even number of 1 bits (0x00 gives 1).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| exec_en | input | 1 | Execute strobe; registers update only when high |
| op_sel | input | 4 | Operation select code |
| operand | input | 8 | Resolved operand byte |
| acc_q | output | 8 | Accumulator contents |
| flags_q | output | 5 | Flags {sign, zero, aux carry, parity, carry} |

## Verification
The assertions assume that `exec_en`, `op_sel` and `operand` are stable and known around every rising edge once the synchronized reset has released. They also assume that each strobed operation is judged only against the accumulator and flags held just before that edge. The bench drives every input on the falling edge and keeps the strobe low throughout reset and the two synchronizer cycles. It also keeps it low whenever it intends an idle cycle, so that every edge sees one settled, defined operation.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

  localparam int OP_W   = 4;
  localparam int FLAG_W = 5;

  typedef enum logic [OP_W-1:0] {
    OP_AND = 4'd0,
    OP_XOR = 4'd1,
    OP_OR  = 4'd2,
    OP_CMP = 4'd3,
    OP_RLC = 4'd4,
    OP_RRC = 4'd5,
    OP_RAL = 4'd6,
    OP_RAR = 4'd7,
    OP_CMA = 4'd8,
    OP_CMC = 4'd9,
    OP_STC = 4'd10
  } op_e;

  localparam logic [OP_W-1:0] OP_LAST = 4'd10;

  typedef struct packed {
    logic sgn;
    logic zro;
    logic aux;
    logic par;
    logic cry;
  } flag_t;

endpackage

// File: rtl/acc_rst_sync.sv
module acc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_single
      always_comb chain_d = 1'b1;
    end else begin : g_multi
      always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign srst_n = chain_q[STAGES-1];

endmodule

// File: rtl/acc_logic_core.sv
module acc_logic_core
  import acc_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  op_e          op,
  output logic [W-1:0] res,
  output logic [W-1:0] diff,
  output logic         lt,
  output logic         eq,
  output logic         nib_borrow
);

  localparam int NIB_W = (W < 8) ? (W / 2) : 4;

  always_comb begin
    unique case (op)
      OP_AND:  res = a & b;
      OP_XOR:  res = a ^ b;
      OP_OR:   res = a | b;
      default: res = '0;
    endcase
  end

  always_comb begin
    diff       = a - b;
    lt         = (a < b);
    eq         = (a == b);
    nib_borrow = (a[NIB_W-1:0] < b[NIB_W-1:0]);
  end

endmodule

// File: rtl/acc_rotate_core.sv
module acc_rotate_core
  import acc_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic         cy_in,
  input  op_e          op,
  output logic [W-1:0] res,
  output logic         cy_out
);

  always_comb begin
    res    = a;
    cy_out = cy_in;
    unique case (op)
      OP_RLC: begin
        res    = {a[W-2:0], a[W-1]};
        cy_out = a[W-1];
      end
      OP_RRC: begin
        res    = {a[0], a[W-1:1]};
        cy_out = a[0];
      end
      OP_RAL: begin
        res    = {a[W-2:0], cy_in};
        cy_out = a[W-1];
      end
      OP_RAR: begin
        res    = {cy_in, a[W-1:1]};
        cy_out = a[0];
      end
      default: begin
        res    = a;
        cy_out = cy_in;
      end
    endcase
  end

endmodule

// File: rtl/acc_logic_unit.sv
module acc_logic_unit
  import acc_alu_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int RST_STAGE = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              exec_en,
  input  logic [OP_W-1:0]   op_sel,
  input  logic [DATA_W-1:0] operand,
  output logic [DATA_W-1:0] acc_q,
  output logic [FLAG_W-1:0] flags_q
);

  logic              rst_n_int;
  op_e               op;
  flag_t             fl_q, fl_d;
  logic [DATA_W-1:0] acc_r, acc_d;
  logic [DATA_W-1:0] lg_res, lg_diff, rot_res;
  logic              lg_lt, lg_eq, lg_nib;
  logic              rot_cy;
  logic              op_valid;

  acc_rst_sync #(.STAGES(RST_STAGE)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_n_int)
  );

  assign op       = op_e'(op_sel);
  assign op_valid = (op_sel <= OP_LAST);

  acc_logic_core #(.W(DATA_W)) u_logic (
    .a          (acc_r),
    .b          (operand),
    .op         (op),
    .res        (lg_res),
    .diff       (lg_diff),
    .lt         (lg_lt),
    .eq         (lg_eq),
    .nib_borrow (lg_nib)
  );

  acc_rotate_core #(.W(DATA_W)) u_rot (
    .a      (acc_r),
    .cy_in  (fl_q.cry),
    .op     (op),
    .res    (rot_res),
    .cy_out (rot_cy)
  );

  // next-state
  always_comb begin
    acc_d = acc_r;
    fl_d  = fl_q;
    if (op_valid) begin
      case (op)
        OP_AND, OP_XOR, OP_OR: begin
          acc_d    = lg_res;
          fl_d.sgn = lg_res[DATA_W-1];
          fl_d.zro = ~|lg_res;
          fl_d.par = ~^lg_res;
          fl_d.cry = 1'b0;
          fl_d.aux = (op == OP_AND);
        end
        OP_CMP: begin
          fl_d.sgn = lg_diff[DATA_W-1];
          fl_d.zro = lg_eq;
          fl_d.par = ~^lg_diff;
          fl_d.aux = lg_nib;
          fl_d.cry = lg_lt;
        end
        OP_RLC, OP_RRC, OP_RAL, OP_RAR: begin
          acc_d    = rot_res;
          fl_d.cry = rot_cy;
        end
        OP_CMA: acc_d    = ~acc_r;
        OP_CMC: fl_d.cry = ~fl_q.cry;
        OP_STC: fl_d.cry = 1'b1;
        default: ;
      endcase
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      acc_r <= '0;
      fl_q  <= '0;
    end else if (exec_en) begin
      acc_r <= acc_d;
      fl_q  <= fl_d;
    end
  end

  assign acc_q   = acc_r;
  assign flags_q = fl_q;

endmodule

// File: rtl/acc_logic_unit_chk.sv
module acc_logic_unit_chk
  import acc_alu_pkg::*;
#(
  parameter int W = 8
) (
  input logic            clk,
  input logic            rst_n_int,
  input logic            exec_en,
  input logic [OP_W-1:0] op_sel,
  input logic [W-1:0]    operand,
  input logic [W-1:0]    acc_q,
  input logic [4:0]      flags_q
);

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n_int)
    (!exec_en || op_sel > OP_LAST) |=> ($stable(acc_q) && $stable(flags_q))); // R2

  AST_AND_FLAGS: assert property (@(posedge clk) disable iff (!rst_n_int)
    (exec_en && op_sel == OP_AND) |=> (flags_q[2] && !flags_q[0]
      && acc_q == ($past(acc_q) & $past(operand)))); // R3

  AST_OR_XOR_CLR: assert property (@(posedge clk) disable iff (!rst_n_int)
    (exec_en && (op_sel == OP_OR || op_sel == OP_XOR)) |=> (!flags_q[2] && !flags_q[0])); // R4

  AST_CMP_ORDER: assert property (@(posedge clk) disable iff (!rst_n_int)
    (exec_en && op_sel == OP_CMP) |=> ($stable(acc_q)
      && flags_q[0] == ($past(acc_q) < $past(operand))
      && flags_q[3] == ($past(acc_q) == $past(operand)))); // R5

  AST_ROT_FLAGS_KEEP: assert property (@(posedge clk) disable iff (!rst_n_int)
    (exec_en && op_sel >= OP_RLC && op_sel <= OP_RAR) |=> (flags_q[4:1] == $past(flags_q[4:1]))); // R7

  AST_RAL_CARRY_IN: assert property (@(posedge clk) disable iff (!rst_n_int)
    (exec_en && op_sel == OP_RAL) |=> (acc_q[0] == $past(flags_q[0]) && flags_q[0] == $past(acc_q[W-1]))); // R8

  AST_CMA_INVERT: assert property (@(posedge clk) disable iff (!rst_n_int)
    (exec_en && op_sel == OP_CMA) |=> (acc_q == ~$past(acc_q) && $stable(flags_q))); // R9

  AST_STC_SETS: assert property (@(posedge clk) disable iff (!rst_n_int)
    (exec_en && op_sel == OP_STC) |=> (flags_q[0] && $stable(acc_q) && flags_q[4:1] == $past(flags_q[4:1]))); // R10

  AST_CMC_FLIPS: assert property (@(posedge clk) disable iff (!rst_n_int)
    (exec_en && op_sel == OP_CMC) |=> (flags_q[0] != $past(flags_q[0]) && $stable(acc_q))); // R10

  AST_RESET_ZERO: assert property (@(posedge clk)
    (!rst_n_int) |-> (acc_q == '0 && flags_q == '0)); // R1

endmodule

bind acc_logic_unit acc_logic_unit_chk #(.W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n_int (rst_n_int),
  .exec_en   (exec_en),
  .op_sel    (op_sel),
  .operand   (operand),
  .acc_q     (acc_q),
  .flags_q   (flags_q)
);

// File: tb/sim_acc_logic_unit.sv
module sim_acc_logic_unit;

  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic [7:0] acc;
    logic [4:0] fl;
    string      tag;
  } exp_t;

  logic       clk;
  logic       rst_n;
  logic       exec_en;
  logic [3:0] op_sel;
  logic [7:0] operand;
  logic [7:0] acc_q;
  logic [4:0] flags_q;

  exp_t       sb_q[$];
  logic [7:0] m_acc;
  logic [4:0] m_fl;   // {s,z,ac,p,cy}
  int         n_vec;
  int         n_bad;
  bit         done;

  acc_logic_unit u0 (
    .clk     (clk),
    .rst_n   (rst_n),
    .exec_en (exec_en),
    .op_sel  (op_sel),
    .operand (operand),
    .acc_q   (acc_q),
    .flags_q (flags_q)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic string tag_of(input logic en, input logic [3:0] op);
    if (!en || op > 4'd10) return "R2";
    case (op)
      4'd0: return "R3";
      4'd1, 4'd2: return "R4";
      4'd3: return "R5/R6";
      4'd4, 4'd5: return "R7";
      4'd6, 4'd7: return "R8";
      4'd8: return "R9";
      default: return "R10";
    endcase
  endfunction

  // reference model built from the requirement list
  task automatic model_step(input logic en, input logic [3:0] op, input logic [7:0] d);
    logic [7:0] r;
    logic       cy;
    cy = m_fl[0];
    if (!en) return;
    case (op)
      4'd0, 4'd1, 4'd2: begin
        r = (op == 4'd0) ? (m_acc & d) : (op == 4'd1) ? (m_acc ^ d) : (m_acc | d);
        m_acc = r;
        m_fl  = {r[7], (r == 8'h00), (op == 4'd0), ~^r, 1'b0};
      end
      4'd3: begin
        r    = m_acc - d;
        m_fl = {r[7], (m_acc == d), (m_acc[3:0] < d[3:0]), ~^r, (m_acc < d)};
      end
      4'd4: begin m_fl[0] = m_acc[7]; m_acc = {m_acc[6:0], m_acc[7]}; end
      4'd5: begin m_fl[0] = m_acc[0]; m_acc = {m_acc[0], m_acc[7:1]}; end
      4'd6: begin m_fl[0] = m_acc[7]; m_acc = {m_acc[6:0], cy}; end
      4'd7: begin m_fl[0] = m_acc[0]; m_acc = {cy, m_acc[7:1]}; end
      4'd8: m_acc = ~m_acc;
      4'd9: m_fl[0] = ~cy;
      4'd10: m_fl[0] = 1'b1;
      default: ;
    endcase
  endtask

  task automatic apply(input logic en, input logic [3:0] op, input logic [7:0] d);
    exp_t e;
    @(negedge clk);
    exec_en = en;
    op_sel  = op;
    operand = d;
    model_step(en, op, d);
    e.acc = m_acc;
    e.fl  = m_fl;
    e.tag = tag_of(en, op);
    sb_q.push_back(e);
  endtask

  task automatic do_reset();
    exp_t e;
    @(negedge clk);
    exec_en = 1'b0;
    rst_n   = 1'b0;
    m_acc   = 8'h00;
    m_fl    = 5'h00;
    e.acc = 8'h00; e.fl = 5'h00; e.tag = "R1";
    sb_q.push_back(e);
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 3; i++) apply(1'b0, 4'd0, 8'h00);
  endtask

  // monitor
  initial begin
    exp_t e;
    forever begin
      @(posedge clk);
      #(CLK_PERIOD/4);
      if (sb_q.size() > 0) begin
        e = sb_q.pop_front();
        n_vec++;
        if (acc_q !== e.acc || flags_q !== e.fl) begin
          n_bad++;
          $display("FAIL %s: acc=%h flags=%b expected acc=%h flags=%b",
                   e.tag, acc_q, flags_q, e.acc, e.fl);
        end
      end
    end
  end

  // watchdog
  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    n_vec = 0; n_bad = 0; done = 1'b0;
    rst_n = 1'b0; exec_en = 1'b0; op_sel = 4'd0; operand = 8'h00;
    m_acc = 8'h00; m_fl = 5'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: registers stay zero through synchronizer release
    for (int i = 0; i < 3; i++) apply(1'b0, 4'd0, 8'h00);

    apply(1'b1, 4'd2, 8'h5A);   // R4 OR load, parity even
    apply(1'b1, 4'd0, 8'h0F);   // R3 AND
    apply(1'b1, 4'd0, 8'h00);   // R3 zero result, R11 parity of 0
    apply(1'b1, 4'd1, 8'h81);   // R4 XOR, sign set
    apply(1'b1, 4'd3, 8'h81);   // R5 equal
    apply(1'b1, 4'd3, 8'hFF);   // R5 less, R6 nibble borrow
    apply(1'b1, 4'd3, 8'h00);   // R5 greater
    apply(1'b1, 4'd3, 8'h12);   // R6
    apply(1'b1, 4'd10, 8'h00);  // R10 set carry
    apply(1'b1, 4'd6, 8'h00);   // R8 carry into bit 0
    apply(1'b1, 4'd7, 8'h00);   // R8
    apply(1'b1, 4'd4, 8'h00);   // R7
    apply(1'b1, 4'd5, 8'h00);   // R7
    apply(1'b1, 4'd8, 8'h00);   // R9
    apply(1'b1, 4'd9, 8'h00);   // R10 complement carry
    apply(1'b1, 4'd9, 8'h00);   // R10
    apply(1'b0, 4'd8, 8'hAA);   // R2 strobe low
    apply(1'b1, 4'd13, 8'hAA);  // R2 unused code
    apply(1'b1, 4'd15, 8'h55);  // R2 unused code

    lfsr = 16'hACE1;
    for (int i = 0; i < 400; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      apply(lfsr[15:14] != 2'b00, lfsr[3:0], lfsr[11:4]);
    end

    apply(1'b1, 4'd2, 8'hC3);
    do_reset();                 // R1 asynchronous clear mid-run
    apply(1'b1, 4'd3, 8'h01);   // R5 from zero accumulator
    apply(1'b1, 4'd0, 8'hFF);   // R3

    @(negedge clk);
    exec_en = 1'b0;
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule